// File: doc/BRIEF.md
# Chip-8 Variable and Index Load Execute Stage

This block is the single-cycle execute stage for the Chip-8 data-movement opcodes that target the variable file and the index register. Each cycle it takes one 16-bit instruction word with a valid strobe. It holds sixteen 8-bit variables and one 12-bit index register. All architectural writes land on the next rising clock edge.

Three opcode groups are executed locally: an immediate byte load into a variable, a copy from one variable to another, and a load of the index register. A register-group opcode whose low nibble is nonzero is an arithmetic or logic operation. For these the block writes nothing. Instead it presents the opcode's fields and both operand values on a forwarding port, for an external arithmetic unit to use. Any other opcode raises an unhandled flag.

A read port returns any variable, and the index register value is always visible. These let the surrounding pipeline, and the bench, observe the state. Fetch, the program counter, memory access and the arithmetic unit are outside this block.

Top module: `chip8_move_exec`

## Requirements
- R1: Asserting `rst_ni` low clears all sixteen variables and the index register to zero, asynchronously.
- R2: Opcode `6XNN` (top nibble 0x6) writes byte NN (bits [7:0]) into variable X (bits [11:8]) at the next rising edge, and leaves the other variables unchanged.
- R3: Opcode `8XY0` (top nibble 0x8, bits [3:0] zero) copies the pre-edge value of variable Y (bits [7:4]) into variable X at the next rising edge. When X equals Y, the value is unchanged.
- R4: Opcode `8XYN` with bits [3:0] nonzero writes no state. In the same cycle it raises `alu_valid_o` and presents X, Y and N, together with the current values of variables X and Y.
- R5: Opcode `AMMM` (top nibble 0xA) loads the index register with bits [11:0] at the next rising edge. The top nibble of the resulting address is always zero (for example, 0xAD08 gives 0x0D08).
- R6: `done_o` is high in the same cycle as a valid `6XNN`, `8XY0` or `AMMM` instruction, and is low otherwise.
- R7: A valid instruction whose top nibble is anything other than 0x6, 0x8 or 0xA raises `unhandled_o` in the same cycle and changes no state.
- R8: While `instr_valid_i` is low, no state changes and `done_o`, `alu_valid_o` and `unhandled_o` are all low, whatever the instruction word holds.
- R9: Variable loads leave the index register unchanged, and index loads leave every variable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Instruction word |
| instr_valid_i | input | 1 | Instruction word is valid this cycle |
| rd_sel_i | input | 4 | Variable number for the read port |
| rd_data_o | output | 8 | Current value of the selected variable |
| index_o | output | 12 | Current index register value |
| done_o | output | 1 | A locally executed instruction completes this cycle |
| alu_valid_o | output | 1 | Arithmetic/logic opcode forwarded this cycle |
| alu_x_o | output | 4 | Destination variable field X |
| alu_y_o | output | 4 | Source variable field Y |
| alu_op_o | output | 4 | Operation nibble N |
| alu_vx_o | output | 8 | Current value of variable X |
| alu_vy_o | output | 8 | Current value of variable Y |
| unhandled_o | output | 1 | Valid opcode outside the handled groups |

## Verification
The bench builds the block with its default parameters: sixteen 8-bit variables, a 12-bit index and a 16-bit instruction word. At these values every variable number and every opcode top nibble can be driven directly. This brings the self-copy case, the address 0xFFF and all thirteen unhandled nibbles within reach. A behavioural model of the variables and the index is compared on every clock, through the read port and the index output. The read port sweeps across all variables while instructions are streamed. An asynchronous reset is also issued mid-run.

// File: rtl/chip8_mv_pkg.sv
package chip8_mv_pkg;
  localparam int unsigned OPC_W = 4;
  localparam logic [OPC_W-1:0] OPC_IMM = 4'h6;
  localparam logic [OPC_W-1:0] OPC_REG = 4'h8;
  localparam logic [OPC_W-1:0] OPC_IDX = 4'hA;

  typedef enum logic [2:0] {
    GRP_NONE,
    GRP_IMM,
    GRP_COPY,
    GRP_ALU,
    GRP_INDEX
  } grp_e;
endpackage

// File: rtl/chip8_mv_decode.sv
module chip8_mv_decode
  import chip8_mv_pkg::*;
#(
  parameter int unsigned INSTR_W = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned SEL_W   = 4
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               valid_i,
  output logic [SEL_W-1:0]   x_o,
  output logic [SEL_W-1:0]   y_o,
  output logic [3:0]         n_o,
  output logic [DATA_W-1:0]  nn_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               var_we_o,
  output logic               src_imm_o,
  output logic               idx_we_o,
  output logic               alu_valid_o,
  output logic               done_o,
  output logic               unhandled_o
);
  localparam int unsigned OP_LSB = INSTR_W - OPC_W;
  localparam int unsigned X_LSB  = INSTR_W - 2 * OPC_W;
  localparam int unsigned Y_LSB  = INSTR_W - 3 * OPC_W;

  logic [OPC_W-1:0] op;
  grp_e             grp;

  assign op     = instr_i[OP_LSB +: OPC_W];
  assign x_o    = instr_i[X_LSB +: SEL_W];
  assign y_o    = instr_i[Y_LSB +: SEL_W];
  assign n_o    = instr_i[3:0];
  assign nn_o   = instr_i[DATA_W-1:0];
  assign addr_o = instr_i[ADDR_W-1:0];

  always_comb begin
    case (op)
      OPC_IMM: grp = GRP_IMM;
      OPC_REG: grp = (n_o == 4'h0) ? GRP_COPY : GRP_ALU;
      OPC_IDX: grp = GRP_INDEX;
      default: grp = GRP_NONE;
    endcase
  end

  assign var_we_o    = valid_i && (grp == GRP_IMM || grp == GRP_COPY);
  assign src_imm_o   = (grp == GRP_IMM);
  assign idx_we_o    = valid_i && (grp == GRP_INDEX);
  assign alu_valid_o = valid_i && (grp == GRP_ALU);
  assign done_o      = var_we_o || idx_we_o;
  assign unhandled_o = valid_i && (grp == GRP_NONE);
endmodule

// File: rtl/chip8_mv_regfile.sv
module chip8_mv_regfile #(
  parameter int unsigned NUM_VARS = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SEL_W    = $clog2(NUM_VARS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [SEL_W-1:0]           waddr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [SEL_W-1:0]           ra_i,
  input  logic [SEL_W-1:0]           rb_i,
  input  logic [SEL_W-1:0]           rc_i,
  output logic [DATA_W-1:0]          ra_o,
  output logic [DATA_W-1:0]          rb_o,
  output logic [DATA_W-1:0]          rc_o,
  output logic [NUM_VARS*DATA_W-1:0] flat_o
);
  logic [NUM_VARS-1:0][DATA_W-1:0] vars_q;

  for (genvar g = 0; g < NUM_VARS; g++) begin : g_var
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               q <= '0;
      else if (we_i && waddr_i == SEL_W'(g))     q <= wdata_i;
    end
    assign vars_q[g] = q;
  end

  assign ra_o   = vars_q[ra_i];
  assign rb_o   = vars_q[rb_i];
  assign rc_o   = vars_q[rc_i];
  assign flat_o = vars_q;
endmodule

// File: rtl/chip8_mv_index.sv
module chip8_mv_index #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] d_i,
  output logic [ADDR_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/chip8_move_exec.sv
module chip8_move_exec #(
  parameter int unsigned NUM_VARS = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned INSTR_W  = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [INSTR_W-1:0]          instr_i,
  input  logic                        instr_valid_i,
  input  logic [$clog2(NUM_VARS)-1:0] rd_sel_i,
  output logic [DATA_W-1:0]           rd_data_o,
  output logic [ADDR_W-1:0]           index_o,
  output logic                        done_o,
  output logic                        alu_valid_o,
  output logic [$clog2(NUM_VARS)-1:0] alu_x_o,
  output logic [$clog2(NUM_VARS)-1:0] alu_y_o,
  output logic [3:0]                  alu_op_o,
  output logic [DATA_W-1:0]           alu_vx_o,
  output logic [DATA_W-1:0]           alu_vy_o,
  output logic                        unhandled_o
);
  localparam int unsigned SEL_W = $clog2(NUM_VARS);

  logic [SEL_W-1:0]           x, y;
  logic [3:0]                 n;
  logic [DATA_W-1:0]          nn, vx, vy, wdata;
  logic [ADDR_W-1:0]          addr;
  logic                       var_we, src_imm, idx_we;
  logic [NUM_VARS*DATA_W-1:0] vars_flat;

  chip8_mv_decode #(
    .INSTR_W(INSTR_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
  ) u_dec (
    .instr_i     (instr_i),
    .valid_i     (instr_valid_i),
    .x_o         (x),
    .y_o         (y),
    .n_o         (n),
    .nn_o        (nn),
    .addr_o      (addr),
    .var_we_o    (var_we),
    .src_imm_o   (src_imm),
    .idx_we_o    (idx_we),
    .alu_valid_o (alu_valid_o),
    .done_o      (done_o),
    .unhandled_o (unhandled_o)
  );

  // immediate byte or copy source
  assign wdata = src_imm ? nn : vy;

  chip8_mv_regfile #(
    .NUM_VARS(NUM_VARS), .DATA_W(DATA_W), .SEL_W(SEL_W)
  ) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (var_we),
    .waddr_i (x),
    .wdata_i (wdata),
    .ra_i    (x),
    .rb_i    (y),
    .rc_i    (rd_sel_i),
    .ra_o    (vx),
    .rb_o    (vy),
    .rc_o    (rd_data_o),
    .flat_o  (vars_flat)
  );

  chip8_mv_index #(.ADDR_W(ADDR_W)) u_idx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (idx_we),
    .d_i    (addr),
    .q_o    (index_o)
  );

  assign alu_x_o  = x;
  assign alu_y_o  = y;
  assign alu_op_o = n;
  assign alu_vx_o = vx;
  assign alu_vy_o = vy;
endmodule

// File: rtl/chip8_move_exec_chk.sv
module chip8_move_exec_chk #(
  parameter int unsigned NUM_VARS = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned INSTR_W  = 16
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [INSTR_W-1:0]          instr_i,
  input logic                        instr_valid_i,
  input logic [ADDR_W-1:0]           index_o,
  input logic                        done_o,
  input logic                        alu_valid_o,
  input logic                        unhandled_o,
  input logic [DATA_W-1:0]           alu_vx_o,
  input logic [DATA_W-1:0]           alu_vy_o,
  input logic [NUM_VARS*DATA_W-1:0]  vars_flat_i
);
  localparam int unsigned SEL_W = $clog2(NUM_VARS);

  logic [3:0]       op, n;
  logic [SEL_W-1:0] x, y;
  logic [DATA_W-1:0] vx_now, vy_now;
  logic is_imm, is_copy, is_alu, is_idx;

  assign op      = instr_i[INSTR_W-1 -: 4];
  assign x       = instr_i[INSTR_W-5 -: SEL_W];
  assign y       = instr_i[INSTR_W-9 -: SEL_W];
  assign n       = instr_i[3:0];
  assign vx_now  = vars_flat_i[x*DATA_W +: DATA_W];
  assign vy_now  = vars_flat_i[y*DATA_W +: DATA_W];
  assign is_imm  = instr_valid_i && op == 4'h6;
  assign is_copy = instr_valid_i && op == 4'h8 && n == 4'h0;
  assign is_alu  = instr_valid_i && op == 4'h8 && n != 4'h0;
  assign is_idx  = instr_valid_i && op == 4'hA;

  p_imm_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_imm |=> vars_flat_i[$past(x)*DATA_W +: DATA_W] == $past(instr_i[DATA_W-1:0]));

  p_copy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_copy |=> vars_flat_i[$past(x)*DATA_W +: DATA_W] == $past(vy_now));

  p_alu_nowrite_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_alu |=> $stable(vars_flat_i) && $stable(index_o));

  p_alu_operands_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_valid_o |-> alu_vx_o == vx_now && alu_vy_o == vy_now);

  p_index_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_idx |=> index_o == $past(instr_i[ADDR_W-1:0]));

  p_strobes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, alu_valid_o, unhandled_o}));

  p_unhandled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unhandled_o |=> $stable(vars_flat_i) && $stable(index_o));

  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |-> !done_o && !alu_valid_o && !unhandled_o);

  p_idle_state_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |=> $stable(vars_flat_i) && $stable(index_o));

  p_var_keeps_index_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_imm || is_copy) |=> $stable(index_o));

  p_index_keeps_vars_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_idx |=> $stable(vars_flat_i));
endmodule

bind chip8_move_exec chip8_move_exec_chk #(
  .NUM_VARS(NUM_VARS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .INSTR_W(INSTR_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .instr_i       (instr_i),
  .instr_valid_i (instr_valid_i),
  .index_o       (index_o),
  .done_o        (done_o),
  .alu_valid_o   (alu_valid_o),
  .unhandled_o   (unhandled_o),
  .alu_vx_o      (alu_vx_o),
  .alu_vy_o      (alu_vy_o),
  .vars_flat_i   (vars_flat)
);

// File: tb/sim_chip8_move_exec.sv
module sim_chip8_move_exec;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic        valid = 1'b0;
  logic [3:0]  rd_sel = '0;
  logic [7:0]  rd_data, alu_vx, alu_vy;
  logic [11:0] index;
  logic        done, alu_valid, unhandled;
  logic [3:0]  alu_x, alu_y, alu_op;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  logic [7:0]  mv[16];
  logic [11:0] mi;
  string       var_req = "R1";
  string       idx_req = "R1";

  always #2 clk = ~clk;

  chip8_move_exec u0 (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .instr_valid_i(valid),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data), .index_o(index), .done_o(done),
    .alu_valid_o(alu_valid), .alu_x_o(alu_x), .alu_y_o(alu_y), .alu_op_o(alu_op),
    .alu_vx_o(alu_vx), .alu_vy_o(alu_vy), .unhandled_o(unhandled)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) mv[i] = '0;
    mi = '0;
    var_req = "R1";
    idx_req = "R1";
  endtask

  // drive one cycle, compare against model, then advance model
  task automatic cyc(input logic [15:0] ins, input logic v, input logic [3:0] sel);
    logic [3:0] op, x, y, n;
    bit e_done, e_alu, e_unh;
    @(negedge clk);
    instr = ins; valid = v; rd_sel = sel;
    #1;
    op = ins[15:12]; x = ins[11:8]; y = ins[7:4]; n = ins[3:0];
    chk(var_req, "rd_data", rd_data, mv[sel]);
    chk(idx_req, "index", index, mi);
    e_done = v && (op == 4'h6 || (op == 4'h8 && n == 0) || op == 4'hA);
    e_alu  = v && op == 4'h8 && n != 0;
    e_unh  = v && !(op == 4'h6 || op == 4'h8 || op == 4'hA);
    chk(v ? "R6" : "R8", "done", done, e_done);
    chk(v ? "R4" : "R8", "alu_valid", alu_valid, e_alu);
    chk(v ? "R7" : "R8", "unhandled", unhandled, e_unh);
    if (e_alu) begin
      chk("R4", "alu fields", {alu_x, alu_y, alu_op}, {x, y, n});
      chk("R4", "alu operands", {alu_vx, alu_vy}, {mv[x], mv[y]});
    end
    if (!v) begin
      var_req = "R8"; idx_req = "R8";
    end else if (op == 4'h6) begin
      mv[x] = ins[7:0]; var_req = "R2"; idx_req = "R9";
    end else if (op == 4'h8 && n == 0) begin
      mv[x] = mv[y]; var_req = "R3"; idx_req = "R9";
    end else if (op == 4'h8) begin
      var_req = "R4"; idx_req = "R4";
    end else if (op == 4'hA) begin
      mi = ins[11:0]; var_req = "R9"; idx_req = "R5";
    end else begin
      var_req = "R7"; idx_req = "R7";
    end
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      valid = 1'b0; rd_sel = 4'(i);
      #1;
      chk(req, "sweep", rd_data, mv[i]);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "index in reset", index, 0);
    @(negedge clk); rst_n = 1'b1;
    sweep("R1");

    cyc(16'h63AB, 1, 4'h3);          // R2
    cyc(16'h6C5A, 1, 4'h3);          // R2
    cyc(16'h85C0, 1, 4'h5);          // R3
    cyc(16'h8330, 1, 4'h5);          // R3 self copy
    cyc(16'hAD08, 1, 4'h3);          // R5
    cyc(16'h0000, 0, 4'hC);          // check 0x0D08
    cyc(16'hAFFF, 1, 4'h0);          // R5 edge
    cyc(16'h8C35, 1, 4'h0);          // R4
    cyc(16'h8C3E, 1, 4'hC);          // R4
    cyc(16'h1234, 1, 4'hC);          // R7
    cyc(16'hF355, 1, 4'h3);          // R7
    cyc(16'h7123, 1, 4'h1);          // R7
    cyc(16'h6177, 0, 4'h1);          // R8 ignored immediate
    cyc(16'hA123, 0, 4'h1);          // R8 ignored index load
    cyc(16'h6E01, 1, 4'hE);          // R9
    sweep("R9");

    for (int k = 0; k < 3000; k++) begin
      logic [15:0] w;
      logic        v;
      int          kind;
      w = 16'($urandom);
      v = 1'b1;
      kind = int'($urandom % 6);
      case (kind)
        0: w[15:12] = 4'h6;
        1: begin w[15:12] = 4'h8; w[3:0] = 4'h0; end
        2: begin w[15:12] = 4'h8; if (w[3:0] == 0) w[3:0] = 4'h1; end
        3: w[15:12] = 4'hA;
        4: if (w[15:12] == 4'h6 || w[15:12] == 4'h8 || w[15:12] == 4'hA) w[15:12] ^= 4'h1;
        default: v = 1'b0;
      endcase
      cyc(w, v, 4'($urandom));
    end
    sweep("R2");

    @(negedge clk); valid = 1'b0; rst_n = 1'b0;
    #1;
    model_reset();
    chk("R1", "index after async reset", index, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    sweep("R1");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule